// File: doc/BRIEF.md
# DMA Transfer Count and Repeat Controller

This block keeps the transfer count and the memory address for one DMA channel. Software loads a count register and an address register, then sets the channel enable. The channel's transfer engine sends a strobe for each completed transfer. On each strobe the block decrements the count and moves the address up, down, or not at all, by one byte or one word. The block also decides when the channel must stop.

In sequential and idle modes, the whole count register acts as one down counter. The channel disables itself after the last transfer. In repeat mode, the count register splits into two bytes. The upper byte keeps the block length and the lower byte counts down through the current block. At the end of each block, the counter reloads from the upper byte and the address returns to the value it held when the channel was enabled. The enable stays set, so blocks repeat until software clears it. In every mode, the transfer that finishes a count raises a one-cycle end-of-block pulse.

Top module: `dma_count_ctrl`

## Requirements
- R1: In sequential mode (`mode_i`=00), idle mode (01) and the reserved code 11 (which behaves as sequential), each accepted transfer (`xfer_done_i` high while `en_o` is high) decrements the full 16-bit count by one.
- R2: In those modes, a loaded count of 0 gives 65,536 transfers: the first transfer makes the count 0xFFFF and the enable stays set.
- R3: In those modes, the transfer that takes the count from 1 to 0 clears `en_o` on the same edge. After that, strobes change neither the count nor the address.
- R4: In repeat mode (`mode_i`=10), the low byte decrements per transfer. When it would reach zero, it is reloaded from the high byte on that edge. The high byte never changes, and a low byte of 0 counts 256 transfers.
- R5: In repeat mode, at each reload the address is restored to the value it held when `en_o` went from 0 to 1.
- R6: In repeat mode, the end of a block does not clear `en_o`. Only `en_clr_i` stops the channel.
- R7: Each accepted transfer moves the address by `step_dir_i`: 01 adds, 10 subtracts, 00 and 11 hold. The step is 1 when `step_size_i`=0 and 2 when it is 1.
- R8: `blk_end_o` is high for exactly the one cycle after a transfer that ends a count, in every mode.
- R9: A count write in the same cycle as a transfer takes the written value, with no decrement and no end pulse. An address write in the same cycle as a transfer takes the written value, with no step.
- R10: Reset clears `en_o`, `blk_end_o` and the address. The count register keeps its value across reset.
- R11: `en_set_i` sets the enable and `en_clr_i` clears it. A clear wins over a set. While the enable is low, strobes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | CW (16) | Count write data |
| addr_we_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | AW (24) | Address write data |
| mode_i | input | 2 | 00 sequential, 01 idle, 10 repeat, 11 as sequential |
| step_dir_i | input | 2 | 01 increment, 10 decrement, 00/11 hold |
| step_size_i | input | 1 | 0 byte step, 1 word step |
| en_set_i | input | 1 | Set channel enable |
| en_clr_i | input | 1 | Clear channel enable (wins over set) |
| xfer_done_i | input | 1 | One completed transfer |
| cnt_o | output | CW (16) | Count register readback |
| addr_o | output | AW (24) | Address register readback |
| en_o | output | 1 | Channel enable |
| blk_end_o | output | 1 | One-cycle end-of-count pulse |

## Verification
A wrong count decrement appears on `cnt_o` at the first edge after the faulty transfer. A missed or wrong terminal detection shows up a cycle later as a missing `blk_end_o` pulse, together with an enable that stays set (sequential) or a low byte that wraps instead of reloading (repeat). A wrong start-address latch stays hidden until the first repeat reload, when `addr_o` jumps to the wrong value. For this reason, the repeat tests run across at least one full block with a moving address. A broken write priority shows on the edge of the collision itself, as a count one below the written value or an address one step away from it.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_SEQ  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_RPT  = 2'b10,
    MODE_RSV  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_KEEP = 2'b11
  } step_dir_e;
endpackage

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          rpt_i,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          term_o
);
  localparam int unsigned HW = CW / 2;
  localparam logic [HW-1:0] LO_ONE = {{(HW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] FULL_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [HW-1:0] lo, hi;
  assign lo = cnt_i[HW-1:0];
  assign hi = cnt_i[CW-1:HW];

  always_comb begin
    if (rpt_i) begin
      term_o = (lo == LO_ONE);
      // reload low half from stored block length
      cnt_nxt_o = term_o ? {hi, hi} : {hi, lo - LO_ONE};
    end else begin
      term_o    = (cnt_i == FULL_ONE);
      cnt_nxt_o = cnt_i - FULL_ONE;
    end
  end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int unsigned AW         = 24,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    dir_i,
  input  logic          word_i,
  input  logic          restore_i,
  input  logic [AW-1:0] start_i,
  output logic [AW-1:0] addr_nxt_o
);
  import dma_cnt_pkg::*;

  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(WORD_BYTES);

  logic [AW-1:0] step;
  logic [AW-1:0] stepped;

  generate
    if (WORD_BYTES == 1) begin : g_byte_only
      assign step = STEP_B;
    end else begin : g_sized
      assign step = word_i ? STEP_W : STEP_B;
    end
  endgenerate

  always_comb begin
    unique case (step_dir_e'(dir_i))
      STEP_INC: stepped = addr_i + step;
      STEP_DEC: stepped = addr_i - step;
      default:  stepped = addr_i;
    endcase
    addr_nxt_o = restore_i ? start_i : stepped;
  end
endmodule

// File: rtl/dma_en_ctrl.sv
module dma_en_ctrl #(
  parameter int unsigned AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic          stop_i,
  input  logic [AW-1:0] addr_cur_i,
  output logic          en_o,
  output logic [AW-1:0] start_o
);
  logic en_q;
  logic [AW-1:0] start_q;
  logic rise;

  assign rise = set_i & ~clr_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      start_q <= '0;
    end else begin
      if (clr_i || stop_i) en_q <= 1'b0;
      else if (set_i)      en_q <= 1'b1;
      if (rise) start_q <= addr_cur_i;
    end
  end

  assign en_o    = en_q;
  assign start_o = start_q;
endmodule

// File: rtl/dma_count_ctrl.sv
module dma_count_ctrl #(
  parameter int unsigned CW         = 16,
  parameter int unsigned AW         = 24,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_wdata_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    step_dir_i,
  input  logic          step_size_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          xfer_done_i,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] addr_o,
  output logic          en_o,
  output logic          blk_end_o
);
  import dma_cnt_pkg::*;

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [AW-1:0] addr_q, addr_nxt, start_addr, addr_cur;
  logic          en_q, rpt, term, xfer_go, cnt_go, end_go, blk_end_q;

  assign rpt     = (xfer_mode_e'(mode_i) == MODE_RPT);
  assign xfer_go = xfer_done_i & en_q;
  assign cnt_go  = xfer_go & ~cnt_we_i;   // CPU count write beats decrement
  assign end_go  = cnt_go & term;
  // start copy sees an address written in the same cycle as the enable
  assign addr_cur = addr_we_i ? addr_wdata_i : addr_q;

  dma_cnt_unit #(.CW(CW)) i_cnt (
    .cnt_i     (cnt_q),
    .rpt_i     (rpt),
    .cnt_nxt_o (cnt_nxt),
    .term_o    (term)
  );

  dma_addr_unit #(.AW(AW), .WORD_BYTES(WORD_BYTES)) i_addr (
    .addr_i     (addr_q),
    .dir_i      (step_dir_i),
    .word_i     (step_size_i),
    .restore_i  (end_go & rpt),
    .start_i    (start_addr),
    .addr_nxt_o (addr_nxt)
  );

  dma_en_ctrl #(.AW(AW)) i_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (en_set_i),
    .clr_i      (en_clr_i),
    .stop_i     (end_go & ~rpt),
    .addr_cur_i (addr_cur),
    .en_o       (en_q),
    .start_o    (start_addr)
  );

  // count register deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (cnt_we_i)    cnt_q <= cnt_wdata_i;
    else if (cnt_go) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      blk_end_q <= 1'b0;
    end else begin
      if (addr_we_i)    addr_q <= addr_wdata_i;
      else if (xfer_go) addr_q <= addr_nxt;
      blk_end_q <= end_go;
    end
  end

  assign cnt_o     = cnt_q;
  assign addr_o    = addr_q;
  assign en_o      = en_q;
  assign blk_end_o = blk_end_q;
endmodule

// File: rtl/dma_count_ctrl_chk.sv
module dma_count_ctrl_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cnt_we_i,
  input logic [CW-1:0] cnt_wdata_i,
  input logic [1:0]    mode_i,
  input logic          en_clr_i,
  input logic          xfer_done_i,
  input logic [CW-1:0] cnt_o,
  input logic          en_o,
  input logic          blk_end_o
);
  localparam int unsigned HW = CW / 2;
  localparam logic [CW-1:0] C_ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [HW-1:0] L_ONE = {{(HW-1){1'b0}}, 1'b1};

  logic go;
  assign go = en_o & xfer_done_i & ~cnt_we_i;

  p_seq_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i != 2'b10) |=> (cnt_o == $past(cnt_o) - C_ONE));

  p_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i != 2'b10 && cnt_o == C_ONE) |=> !en_o);

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i == 2'b10 && cnt_o[HW-1:0] == L_ONE)
      |=> (cnt_o[HW-1:0] == $past(cnt_o[CW-1:HW]) && cnt_o[CW-1:HW] == $past(cnt_o[CW-1:HW])));

  p_rpt_keep_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && mode_i == 2'b10 && !en_clr_i) |=> en_o);

  p_pulse_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_o |-> $past(go));

  p_cnt_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i) && !blk_end_o));

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> !en_o);
endmodule

bind dma_count_ctrl dma_count_ctrl_chk #(.CW(CW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_we_i    (cnt_we_i),
  .cnt_wdata_i (cnt_wdata_i),
  .mode_i      (mode_i),
  .en_clr_i    (en_clr_i),
  .xfer_done_i (xfer_done_i),
  .cnt_o       (cnt_o),
  .en_o        (en_o),
  .blk_end_o   (blk_end_o)
);

// File: tb/test_dma_count_ctrl.sv
`timescale 1ns/1ps
module test_dma_count_ctrl;
  localparam int unsigned CW = 16;
  localparam int unsigned AW = 24;
  localparam int NV = 7;

  // mode, dir, size, initial count, transfers, exp count, exp en, exp addr, exp pulses
  localparam logic [1:0]  V_MODE [NV] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b10, 2'b00, 2'b11};
  localparam logic [1:0]  V_DIR  [NV] = '{2'b01, 2'b10, 2'b00, 2'b01, 2'b01, 2'b01, 2'b11};
  localparam logic        V_SIZE [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [15:0] V_CNT  [NV] = '{16'd5, 16'd3, 16'd4, 16'h0303, 16'h0403, 16'd2, 16'd2};
  localparam int          V_N    [NV] = '{3, 3, 2, 3, 4, 4, 2};
  localparam logic [15:0] V_ECNT [NV] = '{16'd2, 16'd0, 16'd2, 16'h0303, 16'h0403, 16'd0, 16'd0};
  localparam logic        V_EEN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [23:0] V_EADR [NV] = '{24'h001003, 24'h000FFA, 24'h001000, 24'h001000,
                                          24'h001002, 24'h001002, 24'h001000};
  localparam int          V_EPUL [NV] = '{0, 1, 0, 1, 1, 1, 1};
  localparam string       V_REQ  [NV] = '{"R1/R7", "R3/R7", "R1", "R4/R5", "R5/R7", "R3", "R1/R3"};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_we_i = 1'b0, addr_we_i = 1'b0;
  logic [CW-1:0] cnt_wdata_i = '0;
  logic [AW-1:0] addr_wdata_i = '0;
  logic [1:0] mode_i = 2'b00, step_dir_i = 2'b00;
  logic step_size_i = 1'b0, en_set_i = 1'b0, en_clr_i = 1'b0, xfer_done_i = 1'b0;
  logic [CW-1:0] cnt_o;
  logic [AW-1:0] addr_o;
  logic en_o, blk_end_o;

  int total = 0, bad = 0, pulses = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_count_ctrl i_dma_count_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .addr_we_i(addr_we_i), .addr_wdata_i(addr_wdata_i), .mode_i(mode_i),
    .step_dir_i(step_dir_i), .step_size_i(step_size_i), .en_set_i(en_set_i),
    .en_clr_i(en_clr_i), .xfer_done_i(xfer_done_i), .cnt_o(cnt_o), .addr_o(addr_o),
    .en_o(en_o), .blk_end_o(blk_end_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
    if (blk_end_o) pulses++;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] d, input logic s,
                       input logic [15:0] c, input logic [23:0] a);
    en_clr_i = 1'b1; tick(); en_clr_i = 1'b0;
    mode_i = m; step_dir_i = d; step_size_i = s;
    cnt_we_i = 1'b1; cnt_wdata_i = c; addr_we_i = 1'b1; addr_wdata_i = a;
    tick();
    cnt_we_i = 1'b0; addr_we_i = 1'b0;
    en_set_i = 1'b1; tick(); en_set_i = 1'b0;
  endtask

  task automatic xfers(input int n);
    xfer_done_i = 1'b1;
    for (int k = 0; k < n; k++) tick();
    xfer_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R10 reset state
    chk("R10 en", en_o, 0);
    chk("R10 addr", addr_o, 0);
    chk("R10 blk_end", blk_end_o, 0);
    rst_ni = 1'b1;
    tick();

    for (int v = 0; v < NV; v++) begin
      setup(V_MODE[v], V_DIR[v], V_SIZE[v], V_CNT[v], 24'h001000);
      pulses = 0;
      xfers(V_N[v]);
      tick();
      chk({V_REQ[v], " cnt"}, cnt_o, V_ECNT[v]);
      chk({V_REQ[v], " en"}, en_o, V_EEN[v]);
      chk({V_REQ[v], " addr"}, addr_o, V_EADR[v]);
      chk({V_REQ[v], " R8 pulses"}, pulses, V_EPUL[v]);
    end

    // R2: zero load counts 65536
    setup(2'b00, 2'b00, 1'b0, 16'h0000, 24'h000000);
    pulses = 0;
    xfers(1);
    chk("R2 cnt after one", cnt_o, 16'hFFFF);
    chk("R2 en after one", en_o, 1);
    xfers(65534);
    chk("R2 en before last", en_o, 1);
    chk("R2 pulses before last", pulses, 0);
    xfers(1);
    chk("R2 en after 65536", en_o, 0);
    chk("R2 cnt after 65536", cnt_o, 0);
    chk("R8 one pulse", pulses, 1);
    xfers(2);
    chk("R3 cnt after stop", cnt_o, 0);

    // R4/R5/R6: repeat with low byte 0 counts 256
    setup(2'b10, 2'b01, 1'b0, 16'h0500, 24'h002000);
    pulses = 0;
    xfers(255);
    chk("R4 cnt at 255", cnt_o, 16'h0501);
    chk("R7 addr at 255", addr_o, 24'h0020FF);
    chk("R4 no early pulse", pulses, 0);
    xfers(1);
    chk("R4 reload", cnt_o, 16'h0505);
    chk("R5 restore", addr_o, 24'h002000);
    chk("R6 en kept", en_o, 1);
    chk("R8 pulse", pulses, 1);

    // R9: writes beat transfer in the same cycle
    pulses = 0;
    xfer_done_i = 1'b1; cnt_we_i = 1'b1; cnt_wdata_i = 16'h0201;
    addr_we_i = 1'b1; addr_wdata_i = 24'h003000;
    tick();
    xfer_done_i = 1'b0; cnt_we_i = 1'b0; addr_we_i = 1'b0;
    chk("R9 cnt write wins", cnt_o, 16'h0201);
    chk("R9 addr write wins", addr_o, 24'h003000);
    chk("R9 no pulse", pulses, 0);

    // R11: clear stops transfers
    en_clr_i = 1'b1; tick(); en_clr_i = 1'b0;
    chk("R11 cleared", en_o, 0);
    xfers(3);
    chk("R11 cnt frozen", cnt_o, 16'h0201);
    chk("R11 addr frozen", addr_o, 24'h003000);
    en_set_i = 1'b1; en_clr_i = 1'b1; tick();
    en_set_i = 1'b0; en_clr_i = 1'b0;
    chk("R11 clear wins", en_o, 0);

    // R8: pulse lasts one cycle
    setup(2'b00, 2'b00, 1'b0, 16'h0001, 24'h000000);
    xfers(1);
    chk("R8 pulse high", blk_end_o, 1);
    chk("R3 en dropped", en_o, 0);
    tick();
    chk("R8 pulse low", blk_end_o, 0);

    // R10: count survives reset
    cnt_we_i = 1'b1; cnt_wdata_i = 16'h1234; tick(); cnt_we_i = 1'b0;
    en_set_i = 1'b1; tick(); en_set_i = 1'b0;
    #2 rst_ni = 1'b0;
    #10;
    chk("R10 cnt kept", cnt_o, 16'h1234);
    chk("R10 en reset", en_o, 0);
    chk("R10 addr reset", addr_o, 0);
    rst_ni = 1'b1;
    tick();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule